// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block reads a small key matrix of row lines and active-low column lines. Column lines float high through pull-ups and go low where a closed key connects them to a row that is being driven low. While the block is parked, every row is driven low. In that state any press or release changes the column pattern. The block watches for such a change. When it sees one, it raises a pending flag and starts a continuous scan. In each scan cycle it drives one row at a time, from row 1 to the last row, and then spends one slot with no row driven.

Columns are read on the last tick of each row slot and inverted, so a set bit means pressed. When the blank slot ends, the assembled key word is offered on a valid/ready output. The producer holds an offered word steady until it is taken. Any scan that completes while a word is still waiting is dropped.

Scanning continues until the serial block pulses a stop request. That block raises the request once the host has completed its two chip-select pulses and the display transfer. On the stop request the rows park low and the pending flag clears. Change detection then re-arms against the column pattern seen with the rows parked. A key that stays held across the stop therefore does not restart the scan.

Top module: `kscan_matrix`

## Requirements
- R1: Out of reset, all rows are driven low (`row_pull` all ones), `key_pending` is 0 and `key_valid` is 0.
- R2: While parked with unchanged columns, the block stays parked with `key_pending` at 0.
- R3: A press or a release seen while parked sets `key_pending` on the third rising clock edge after the column change. The first driven row is then row 1 (`row_pull` = 3'b001).
- R4: During a scan, `row_pull` repeats the sequence 001, 010, 100, 000, where bit 0 is row 1 and the all-zero slot drives no row.
- R5: Every slot lasts exactly `ROW_TICKS` timebase ticks, and a row change during a scan happens only on a tick.
- R6: Key word bit (r-1)*4+(c-1) is 1 exactly when the key at row r, column c is closed. Columns are sampled on the last tick of row r's slot.
- R7: When each blank slot ends, the word from that scan cycle is presented with `key_valid`. A transfer happens on a clock edge where both `key_valid` and `key_ready` are 1. After that edge, `key_valid` drops unless a new scan completed on the same edge.
- R8: While `key_valid` is 1 and `key_ready` is 0, `key_word` stays stable. Scans that complete during this time are discarded.
- R9: A `stop_req` during a scan parks all rows low and clears `key_pending` on the next edge. A word that is waiting stays offered.
- R10: After a stop, keys held unchanged do not restart scanning. A later press or release does restart it.
- R11: A `stop_req` while parked has no effect.
- R12: If `stop_req` arrives on the same edge on which a scan completes, that scan's word is still published and the block parks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick that paces the slots |
| col_n | input | COLS | Column lines, active low |
| row_pull | output | ROWS | 1 = row driven low, 0 = row released |
| stop_req | input | 1 | One-cycle stop request from the serial block |
| key_pending | output | 1 | A key change was seen and scanning is in progress |
| key_valid | output | 1 | Key word offered |
| key_ready | input | 1 | Consumer accepts the offered word |
| key_word | output | ROWS*COLS | Key state, bit (r-1)*COLS+(c-1) = key at row r, column c |

## Verification
Two events can fall on the same clock edge: the end of the blank slot, which publishes a word, and a stop request from the serial side. To make them coincide, the bench switches the timebase to hand-driven ticks once the blank slot begins. It issues `ROW_TICKS-1` ticks, then gives the final tick together with `stop_req`. It then expects the rows parked, `key_pending` cleared, and `key_valid` high with the word for the keys being held. On the next edge it expects that word to be taken.

// File: rtl/kscan_pkg.sv
`timescale 1ns/1ps
package kscan_pkg;
  typedef enum logic [1:0] {
    KS_REARM = 2'd0,
    KS_IDLE  = 2'd1,
    KS_SCAN  = 2'd2
  } kscan_state_e;
endpackage

// File: rtl/kscan_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the column lines; resets to "released".
module kscan_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kscan_change_det.sv
`timescale 1ns/1ps
// Holds the parked column pattern and flags any departure from it.
module kscan_change_det #(
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] col_now,
  input  logic            track,
  input  logic            armed,
  output logic            change
);
  logic [COLS-1:0] ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ref_q <= '1;
    else if (track) ref_q <= col_now;
  end

  assign change = armed && (col_now != ref_q);
endmodule

// File: rtl/kscan_sequencer.sv
`timescale 1ns/1ps
// Park / rearm / scan control, slot and tick counting, row drive.
module kscan_sequencer import kscan_pkg::*; #(
  parameter int ROWS      = 3,
  parameter int ROW_TICKS = 4,
  parameter int REARM_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            change,
  input  logic            stop_req,
  output logic [ROWS-1:0] row_pull,
  output logic [ROWS-1:0] row_strobe,
  output logic            scan_done,
  output logic            scanning,
  output logic            track,
  output logic            armed
);
  localparam int SLOT_W = $clog2(ROWS + 1);
  localparam int TCNT_W = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
  localparam int RC_W   = (REARM_CYC > 1) ? $clog2(REARM_CYC) : 1;
  localparam logic [SLOT_W-1:0] GAP_SLOT  = SLOT_W'(ROWS);
  localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(ROW_TICKS - 1);
  localparam logic [RC_W-1:0]   RC_LAST   = RC_W'(REARM_CYC - 1);

  kscan_state_e      state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [RC_W-1:0]   rcnt_q;
  logic              slot_end;

  assign scanning = (state_q == KS_SCAN);
  assign armed    = (state_q == KS_IDLE);
  assign track    = !scanning;
  assign slot_end = scanning && tick && (tcnt_q == TCNT_LAST);
  assign scan_done = slot_end && (slot_q == GAP_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_REARM;
      slot_q  <= '0;
      tcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      unique case (state_q)
        KS_REARM: begin
          if (rcnt_q == RC_LAST) begin
            state_q <= KS_IDLE;
            rcnt_q  <= '0;
          end else begin
            rcnt_q <= rcnt_q + RC_W'(1);
          end
        end
        KS_IDLE: begin
          if (change) begin
            state_q <= KS_SCAN;
            slot_q  <= '0;
            tcnt_q  <= '0;
          end
        end
        KS_SCAN: begin
          if (stop_req) begin
            state_q <= KS_REARM;
            rcnt_q  <= '0;
            slot_q  <= '0;
            tcnt_q  <= '0;
          end else if (tick) begin
            if (tcnt_q == TCNT_LAST) begin
              tcnt_q <= '0;
              slot_q <= (slot_q == GAP_SLOT) ? '0 : slot_q + SLOT_W'(1);
            end else begin
              tcnt_q <= tcnt_q + TCNT_W'(1);
            end
          end
        end
        default: state_q <= KS_REARM;
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_pull[r]   = !scanning || (slot_q == SLOT_W'(r));
    assign row_strobe[r] = slot_end && (slot_q == SLOT_W'(r));
  end
endmodule

// File: rtl/kscan_collect.sv
`timescale 1ns/1ps
// Assembles the key word row by row and offers it on a valid/ready port.
module kscan_collect #(
  parameter int ROWS = 3,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [COLS-1:0]      col_sync,
  input  logic [ROWS-1:0]      row_strobe,
  input  logic                 scan_done,
  input  logic                 key_ready,
  output logic                 key_valid,
  output logic [ROWS*COLS-1:0] key_word
);
  localparam int KEYS = ROWS * COLS;

  logic [KEYS-1:0] acc_q;
  logic            slot_free;

  assign slot_free = !key_valid || key_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_strobe[r]) acc_q[r*COLS +: COLS] <= ~col_sync;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_valid <= 1'b0;
      key_word  <= '0;
    end else if (scan_done && slot_free) begin
      key_valid <= 1'b1;
      key_word  <= acc_q;
    end else if (key_ready) begin
      key_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kscan_matrix.sv
`timescale 1ns/1ps
// Change-triggered key matrix scanner, top level.
module kscan_matrix #(
  parameter int ROWS        = 3,
  parameter int COLS        = 4,
  parameter int ROW_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [COLS-1:0]      col_n,
  output logic [ROWS-1:0]      row_pull,
  input  logic                 stop_req,
  output logic                 key_pending,
  output logic                 key_valid,
  input  logic                 key_ready,
  output logic [ROWS*COLS-1:0] key_word
);
  localparam int REARM_CYC = SYNC_STAGES + 1;

  logic [COLS-1:0] col_sync;
  logic [ROWS-1:0] row_strobe;
  logic            change, track, armed, scan_done;

  kscan_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(col_n), .q(col_sync)
  );

  kscan_change_det #(.COLS(COLS)) u_det (
    .clk(clk), .rst_n(rst_n), .col_now(col_sync),
    .track(track), .armed(armed), .change(change)
  );

  kscan_sequencer #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS), .REARM_CYC(REARM_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .change(change), .stop_req(stop_req),
    .row_pull(row_pull), .row_strobe(row_strobe), .scan_done(scan_done),
    .scanning(key_pending), .track(track), .armed(armed)
  );

  kscan_collect #(.ROWS(ROWS), .COLS(COLS)) u_col (
    .clk(clk), .rst_n(rst_n), .col_sync(col_sync), .row_strobe(row_strobe),
    .scan_done(scan_done), .key_ready(key_ready),
    .key_valid(key_valid), .key_word(key_word)
  );
endmodule

// File: rtl/kscan_matrix_chk.sv
`timescale 1ns/1ps
module kscan_matrix_chk #(
  parameter int ROWS = 3,
  parameter int COLS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [ROWS-1:0]      row_pull,
  input logic                 stop_req,
  input logic                 key_pending,
  input logic                 key_valid,
  input logic                 key_ready,
  input logic [ROWS*COLS-1:0] key_word
);
  a_r1_parked_rows_low: assert property (@(posedge clk) disable iff (!rst_n)
    !key_pending |-> (&row_pull));

  a_r3_first_row_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pending) |-> (row_pull == ROWS'(1)));

  a_r4_one_row_at_most: assert property (@(posedge clk) disable iff (!rst_n)
    key_pending |-> $onehot0(row_pull));

  a_r5_rows_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (key_pending && $past(key_pending) && (row_pull != $past(row_pull))) |-> $past(tick));

  a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_word)));

  a_r9_stop_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (key_pending && stop_req) |=> (!key_pending && (&row_pull)));
endmodule

bind kscan_matrix kscan_matrix_chk #(.ROWS(ROWS), .COLS(COLS)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .row_pull(row_pull), .stop_req(stop_req),
  .key_pending(key_pending), .key_valid(key_valid), .key_ready(key_ready),
  .key_word(key_word)
);

// File: tb/test_kscan_matrix.sv
`timescale 1ns/1ps
module test_kscan_matrix;
  localparam int ROWS = 3, COLS = 4, ROW_TICKS = 4, TDIV = 3;
  localparam int KEYS = ROWS * COLS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, tick_auto = 1'b1, tick_man = 1'b0;
  logic [1:0] tdiv = '0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_pull;
  logic stop_req = 1'b0, key_pending, key_valid, key_ready = 1'b1;
  logic [KEYS-1:0] key_word;
  logic [KEYS-1:0] pressed = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) tdiv <= (tdiv == 2'(TDIV - 1)) ? '0 : tdiv + 2'd1;
  assign tick = tick_auto ? (tdiv == '0) : tick_man;

  // Key matrix model: a closed key pulls its column low while its row is driven low.
  always_comb begin
    col_n = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (row_pull[r] && pressed[r*COLS+c]) col_n[c] = 1'b0;
  end

  kscan_matrix #(.ROWS(ROWS), .COLS(COLS), .ROW_TICKS(ROW_TICKS)) i_kscan_matrix (
    .clk(clk), .rst_n(rst_n), .tick(tick), .col_n(col_n), .row_pull(row_pull),
    .stop_req(stop_req), .key_pending(key_pending), .key_valid(key_valid),
    .key_ready(key_ready), .key_word(key_word)
  );

  function automatic int kb(int r, int c);
    return (r - 1) * COLS + (c - 1);
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic get_word(output logic [KEYS-1:0] w);
    int n = 0;
    step(1);
    while (!key_valid && n < 2000) begin step(1); n++; end
    w = key_word;
  endtask

  task automatic t_reset();
    step(1);
    check(row_pull == 3'b111, "R1 rows after reset", row_pull, 7);
    check(!key_pending && !key_valid, "R1 pending/valid after reset",
          {key_pending, key_valid}, 0);
  endtask

  task automatic t_quiet();
    step(200);
    check(!key_pending && row_pull == 3'b111, "R2 quiet stays parked",
          {key_pending, row_pull}, 7);
  endtask

  task automatic t_press_start();
    pressed[kb(2,3)] = 1'b1;
    step(2);
    check(!key_pending, "R3 not yet pending after 2 edges", key_pending, 0);
    step(1);
    check(key_pending, "R3 pending after 3 edges", key_pending, 1);
    check(row_pull == 3'b001, "R3 first row is row 1", row_pull, 1);
  endtask

  task automatic t_row_order();
    logic [ROWS-1:0] prev, expn;
    int len = 1, idx = 0;
    bit ok_seq = 1, ok_len = 1;
    prev = row_pull;
    for (int i = 0; i < 120; i++) begin
      step(1);
      if (row_pull == prev) len++;
      else begin
        expn = (prev == 3'b000) ? 3'b001 : (prev == 3'b100 ? 3'b000 : prev << 1);
        if (row_pull != expn) ok_seq = 0;
        if (idx > 0 && len != ROW_TICKS * TDIV) ok_len = 0;
        idx++;
        prev = row_pull;
        len = 1;
      end
    end
    check(ok_seq && idx >= 8, "R4 row order 001,010,100,000", idx, 8);
    check(ok_len, "R5 slot width ROW_TICKS ticks", len, ROW_TICKS * TDIV);
  endtask

  task automatic t_words();
    logic [KEYS-1:0] w;
    get_word(w); get_word(w);
    check(w == 12'h040, "R6 S23 word", w, 12'h040);
    pressed = '0;
    pressed[kb(1,1)] = 1; pressed[kb(2,2)] = 1; pressed[kb(3,4)] = 1;
    get_word(w); get_word(w);
    check(w == 12'h821, "R6 S11+S22+S34 word", w, 12'h821);
    pressed = '1;
    get_word(w); get_word(w);
    check(w == 12'hFFF, "R7 all keys word", w, 12'hFFF);
    pressed = '0;
    get_word(w); get_word(w);
    check(w == 12'h000, "R7 no keys word", w, 0);
    step(1);
    check(!key_valid, "R7 valid drops after transfer", key_valid, 0);
  endtask

  task automatic t_backpressure();
    logic [KEYS-1:0] w;
    pressed = '0; pressed[kb(1,2)] = 1;
    step(100);
    key_ready = 1'b0;
    step(60);
    check(key_valid && key_word == 12'h002, "R8 held word S12", key_word, 12'h002);
    pressed = '0; pressed[kb(3,1)] = 1;
    step(150);
    check(key_valid && key_word == 12'h002, "R8 word stable across scans", key_word, 12'h002);
    key_ready = 1'b1;
    get_word(w); get_word(w);
    check(w == 12'h100, "R8 fresh word after release of back-pressure", w, 12'h100);
  endtask

  task automatic t_stop();
    key_ready = 1'b0;
    step(60);
    stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
    check(!key_pending && row_pull == 3'b111, "R9 stop parks rows",
          {key_pending, row_pull}, 7);
    step(5);
    check(key_valid && key_word == 12'h100, "R9 waiting word kept", key_word, 12'h100);
    key_ready = 1'b1;
    step(200);
    check(!key_pending, "R10 held key does not restart", key_pending, 0);
    pressed = '0;
    step(3);
    check(key_pending, "R10 release restarts scan", key_pending, 1);
  endtask

  task automatic t_idle_stop();
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    step(10);
    check(!key_pending, "R11 parked after stop", key_pending, 0);
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    step(5);
    check(!key_pending && row_pull == 3'b111, "R11 idle stop no effect",
          {key_pending, row_pull}, 7);
    pressed[kb(1,4)] = 1;
    step(3);
    check(key_pending, "R11 detection intact after idle stop", key_pending, 1);
  endtask

  task automatic t_same_cycle();
    logic [KEYS-1:0] w;
    int n = 0;
    pressed = '0; pressed[kb(1,4)] = 1; pressed[kb(3,2)] = 1;
    get_word(w); get_word(w);
    while (row_pull == 3'b000 && n < 500) begin step(1); n++; end
    while (row_pull != 3'b000 && n < 500) begin step(1); n++; end
    tick_auto = 1'b0;
    tick_man  = 1'b1;
    step(ROW_TICKS - 1);
    stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
    tick_man = 1'b0;
    check(!key_pending && row_pull == 3'b111, "R12 parked after coincident stop",
          {key_pending, row_pull}, 7);
    check(key_valid && key_word == 12'h208, "R12 word published with stop", key_word, 12'h208);
    step(1);
    check(!key_valid, "R12 word taken next edge", key_valid, 0);
    tick_auto = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_quiet();
    t_press_start();
    t_row_order();
    t_words();
    t_backpressure();
    t_stop();
    t_idle_stop();
    t_same_cycle();
    summary();
  end
endmodule